// File: doc/BRIEF.md
# GPIO Controller with Alternate-Function Pin Routing

This block drives 32 general-purpose pins from two 16-bit output data registers reached over a simple register read/write bus. A control register can hand two fixed four-pin groups to alternate serial functions: a high-speed serial port on pins 15..12 and a SPI port on pins 11..8. A separate override bit gives pin 15 to the SPI slave-select line, taking priority over every other use of that pin. The serial engines stay outside the block. Their output levels arrive as opaque inputs, pass through the per-pin multiplexer, and leave on the pin outputs. A two-bit function code per pin reports which source each pin is driving.

The block also produces one external interrupt taken from a selected GPIO pin. That pin is synchronised through a two-flop chain. An edge of the chosen polarity then sets a sticky pending flag, but only while both the control-register enable and the separate interrupt-enable bit are set. Software clears the flag by writing 1 to the status register. The interrupt request output is the pending flag gated by both enables.

The register addresses used below are LO_DATA 0xC01E, HI_DATA 0xC024, CTRL 0xC006, IRQ_EN 0xC00E, IRQ_STAT 0xC010, PIN_LO 0xC020 and PIN_HI 0xC022. Read data is combinational from `bus_addr`. A write takes effect on the clock edge on which `bus_wr` is sampled high.

Top module: `gpio_mux_ctrl`

## Requirements
- R1: After a synchronous active-low reset, both data registers, CTRL, IRQ_EN and the pending flag are 0, `pin_out` is 0, `pin_func` is 0 and `irq0` is low.
- R2: Bit n of LO_DATA drives `pin_out[n]` for n = 0..15. A read of LO_DATA returns the value last written, whatever the levels on `pin_in`.
- R3: In HI_DATA, bits 15..13 drive pins 31..29, bit 8 drives pin 24 and bits 7..3 drive pins 23..19. A read returns the writable bits last written.
- R4: Reserved bits read 0 and are ignored on write. These are HI_DATA bits 12..9 and 2..0, CTRL bits other than 7, 5, 4, 1 and 0, and all bits above bit 0 of IRQ_EN and IRQ_STAT. Pins 28..25 and 18..16 are always driven 0.
- R5: With CTRL bit 7 set, pins 15..12 carry `hs_alt_out[3:0]` (pin 12 takes bit 0) and report function code 1. With the bit clear, they carry GPIO data and report code 0.
- R6: With CTRL bit 5 set, pins 11..8 carry `spi_alt_out[3:0]` (pin 8 takes bit 0) and report function code 2.
- R7: With CTRL bit 4 set, pin 15 carries `spi_ss_out` and reports function code 3. This holds whether CTRL bit 7 is set or clear.
- R8: The interrupt pin (pin 0 by default) passes through two synchronising flops and one edge register. CTRL bit 1 selects the edge: 1 is rising and 0 is falling. An edge of that polarity sets the pending flag on the third clock edge after the pin changes. It does so only if CTRL bit 0 and IRQ_EN bit 0 are both 1. An edge of the other polarity does nothing.
- R9: `irq0` equals the pending flag AND CTRL bit 0 AND IRQ_EN bit 0. IRQ_STAT bit 0 reads the pending flag. Writing 1 to that bit clears the flag, and writing 0 leaves it unchanged.
- R10: When a clearing write and a qualifying edge land on the same clock edge, the pending flag ends set.
- R11: PIN_LO and PIN_HI read the current levels of `pin_in[15:0]` and `pin_in[31:16]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| pin_in | input | 32 | Pin input levels |
| hs_alt_out | input | 4 | High-speed serial output levels |
| spi_alt_out | input | 4 | SPI output levels |
| spi_ss_out | input | 1 | SPI slave-select output level |
| pin_out | output | 32 | Per-pin output value |
| pin_func | output | 64 | Two-bit function code per pin (pin i at bits 2i+1..2i) |
| irq0 | output | 1 | Interrupt request |

## Verification
The two functions that can fall in the same cycle are a software clear of the pending flag and a hardware edge that sets it. The bench first leaves the flag set. It then raises the interrupt pin and times a write of 1 to IRQ_STAT so that the write is sampled on the edge at which the synchronised edge reaches the flag, two negative edges after the pin change. It judges the result by `irq0` and by an IRQ_STAT read, both of which must show the flag still set. A lone clear elsewhere in the run shows that the write works when no edge coincides.

// File: rtl/gpio_mux_pkg.sv
// Package gpio_mux_pkg
// Shared constants and types for the GPIO controller: register addresses,
// control-bit positions, writable-bit masks and the per-pin function code.
// Assumes a 16-bit register bus and a 32-pin array split into two halves.
package gpio_mux_pkg;

    localparam int unsigned BUS_W    = 16;
    localparam int unsigned PIN_N    = 32;

    localparam logic [BUS_W-1:0] A_LO_DATA  = 16'hC01E;
    localparam logic [BUS_W-1:0] A_HI_DATA  = 16'hC024;
    localparam logic [BUS_W-1:0] A_CTRL     = 16'hC006;
    localparam logic [BUS_W-1:0] A_IRQ_EN   = 16'hC00E;
    localparam logic [BUS_W-1:0] A_IRQ_STAT = 16'hC010;
    localparam logic [BUS_W-1:0] A_PIN_LO   = 16'hC020;
    localparam logic [BUS_W-1:0] A_PIN_HI   = 16'hC022;

    localparam int unsigned CB_HS_EN  = 7;
    localparam int unsigned CB_SPI_EN = 5;
    localparam int unsigned CB_SS_EN  = 4;
    localparam int unsigned CB_POL    = 1;
    localparam int unsigned CB_IRQ_EN = 0;

    localparam logic [BUS_W-1:0] HI_MASK   = 16'hE1F8;
    localparam logic [BUS_W-1:0] CTRL_MASK = 16'h00B3;

    typedef enum logic [1:0] {
        FN_GPIO = 2'd0,
        FN_HS   = 2'd1,
        FN_SPI  = 2'd2,
        FN_SS   = 2'd3
    } pin_fn_e;

    typedef struct packed {
        logic hs_en;
        logic spi_en;
        logic ss_en;
        logic pol_rise;
        logic irq_en;
    } ctrl_t;

endpackage

// File: rtl/gpio_mux_regs.sv
// Module gpio_mux_regs
// Register file and bus decode: the two output data registers, the control
// register and the interrupt-enable bit, plus the combinational read mux.
// It produces the W1C strobe for the pending flag held in gpio_mux_irq.
// Assumes single-cycle writes; read data follows bus_addr combinationally.
module gpio_mux_regs
    import gpio_mux_pkg::*;
#(
    parameter int unsigned DW = BUS_W,
    parameter int unsigned NP = PIN_N
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [NP-1:0] pin_in,
    input  logic          pending,
    output logic [NP-1:0] gpio_data,
    output ctrl_t         ctrl,
    output logic          ie_gpio,
    output logic          clr_pending
);

    localparam int unsigned HALF = NP / 2;

    logic [DW-1:0] lo_q;
    logic [DW-1:0] hi_q;
    logic [DW-1:0] ctrl_q;
    logic          ie_q;

    logic wr_lo, wr_hi, wr_ctrl, wr_ie, wr_stat;

    // Address decode of the write strobe.
    always_comb begin
        wr_lo   = bus_wr && (bus_addr == A_LO_DATA);
        wr_hi   = bus_wr && (bus_addr == A_HI_DATA);
        wr_ctrl = bus_wr && (bus_addr == A_CTRL);
        wr_ie   = bus_wr && (bus_addr == A_IRQ_EN);
        wr_stat = bus_wr && (bus_addr == A_IRQ_STAT);
    end

    // Output data registers; the high one keeps only its writable bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (wr_lo) lo_q <= bus_wdata;
            if (wr_hi) hi_q <= bus_wdata & HI_MASK;
        end
    end

    // Control and interrupt-enable registers with reserved bits dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ie_q   <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_MASK;
            if (wr_ie)   ie_q   <= bus_wdata[0];
        end
    end

    // Read mux: stored values, status flag and raw pin levels.
    always_comb begin
        unique case (bus_addr)
            A_LO_DATA:  bus_rdata = lo_q;
            A_HI_DATA:  bus_rdata = hi_q;
            A_CTRL:     bus_rdata = ctrl_q;
            A_IRQ_EN:   bus_rdata = {{(DW-1){1'b0}}, ie_q};
            A_IRQ_STAT: bus_rdata = {{(DW-1){1'b0}}, pending};
            A_PIN_LO:   bus_rdata = pin_in[HALF-1:0];
            A_PIN_HI:   bus_rdata = pin_in[NP-1:HALF];
            default:    bus_rdata = '0;
        endcase
    end

    // Field extraction toward the mux and interrupt logic.
    always_comb begin
        gpio_data       = {hi_q, lo_q};
        ctrl.hs_en      = ctrl_q[CB_HS_EN];
        ctrl.spi_en     = ctrl_q[CB_SPI_EN];
        ctrl.ss_en      = ctrl_q[CB_SS_EN];
        ctrl.pol_rise   = ctrl_q[CB_POL];
        ctrl.irq_en     = ctrl_q[CB_IRQ_EN];
        ie_gpio         = ie_q;
        clr_pending     = wr_stat && bus_wdata[0];
    end

    p_lo_write_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_LO_DATA) |=> (lo_q == $past(bus_wdata)));

    p_hi_write_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_HI_DATA) |=> (hi_q == ($past(bus_wdata) & HI_MASK)));

    p_ctrl_reserved_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CTRL) |-> ((bus_rdata & ~CTRL_MASK) == '0));

endmodule

// File: rtl/gpio_mux_pinmux.sv
// Module gpio_mux_pinmux
// Per-pin output multiplexer. Each pin picks GPIO data, a high-speed serial
// line, a SPI line or the slave-select line, and reports a function code.
// Assumes the high-speed and SPI groups do not overlap; the slave-select pin
// may sit inside a group and then outranks it.
module gpio_mux_pinmux
    import gpio_mux_pkg::*;
#(
    parameter int unsigned NP      = PIN_N,
    parameter int unsigned GRP_W   = 4,
    parameter int unsigned HS_BASE = 12,
    parameter int unsigned SPI_BASE = 8,
    parameter int unsigned SS_PIN  = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NP-1:0]   gpio_data,
    input  ctrl_t           ctrl,
    input  logic [GRP_W-1:0] hs_alt,
    input  logic [GRP_W-1:0] spi_alt,
    input  logic            spi_ss,
    output logic [NP-1:0]   pin_out,
    output logic [2*NP-1:0] pin_func
);

    for (genvar i = 0; i < NP; i++) begin : g_pin
        localparam bit IN_HS  = (i >= HS_BASE)  && (i < HS_BASE + GRP_W);
        localparam bit IN_SPI = (i >= SPI_BASE) && (i < SPI_BASE + GRP_W);
        localparam bit IS_SS  = (i == SS_PIN);

        logic    hs_bit, spi_bit, ss_bit;
        logic    val;
        pin_fn_e fn;

        if (IN_HS) begin : g_hs
            assign hs_bit = hs_alt[i - HS_BASE];
        end else begin : g_nohs
            assign hs_bit = 1'b0;
        end

        if (IN_SPI) begin : g_spi
            assign spi_bit = spi_alt[i - SPI_BASE];
        end else begin : g_nospi
            assign spi_bit = 1'b0;
        end

        if (IS_SS) begin : g_ss
            assign ss_bit = spi_ss;
        end else begin : g_noss
            assign ss_bit = 1'b0;
        end

        // Source selection for this pin, slave-select override first.
        always_comb begin
            fn  = FN_GPIO;
            val = gpio_data[i];
            if (IS_SS && ctrl.ss_en) begin
                fn  = FN_SS;
                val = ss_bit;
            end else if (IN_HS && ctrl.hs_en) begin
                fn  = FN_HS;
                val = hs_bit;
            end else if (IN_SPI && ctrl.spi_en) begin
                fn  = FN_SPI;
                val = spi_bit;
            end
        end

        assign pin_out[i]        = val;
        assign pin_func[2*i +: 2] = fn;
    end

    p_ss_priority_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.ss_en |-> (pin_out[SS_PIN] == spi_ss && pin_func[2*SS_PIN +: 2] == FN_SS));

    p_hs_route_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.hs_en && !ctrl.ss_en) |-> (pin_out[HS_BASE +: GRP_W] == hs_alt));

    p_spi_route_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.spi_en |-> (pin_out[SPI_BASE +: GRP_W] == spi_alt));

endmodule

// File: rtl/gpio_mux_irq.sv
// Module gpio_mux_irq
// Interrupt path: a synchroniser chain on the source pin, one edge register,
// polarity select, and a sticky pending flag cleared by a W1C strobe.
// Assumes SYNC_STAGES >= 2. A set and a clear on the same edge leave the
// flag set so that no edge is lost.
module gpio_mux_irq #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_pin,
    input  logic pol_rise,
    input  logic irq_en,
    input  logic ie_gpio,
    input  logic clr_pending,
    output logic pending,
    output logic irq
);

    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   pend_q;
    logic                   rise, fall, hit, arm, set_p;

    // Synchroniser chain and one-cycle delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], src_pin};
            prev_q <= sync_q[LAST];
        end
    end

    // Edge qualification by polarity and both enables.
    always_comb begin
        rise  = sync_q[LAST] & ~prev_q;
        fall  = ~sync_q[LAST] & prev_q;
        hit   = pol_rise ? rise : fall;
        arm   = irq_en & ie_gpio;
        set_p = hit & arm;
    end

    // Sticky pending flag; a coinciding set overrides the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (set_p) begin
            pend_q <= 1'b1;
        end else if (clr_pending) begin
            pend_q <= 1'b0;
        end
    end

    assign pending = pend_q;
    assign irq     = pend_q & arm;

    p_set_wins_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        (set_p && clr_pending) |=> pend_q);

    p_irq_gated_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && ie_gpio && pend_q));

    p_pending_hold_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        (!set_p && !clr_pending) |=> $stable(pend_q));

    p_no_set_disarmed_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> !$rose(pend_q));

endmodule

// File: rtl/gpio_mux_ctrl.sv
// Module gpio_mux_ctrl (top)
// GPIO controller with alternate-function routing and one edge interrupt.
// Joins the register file, the per-pin mux and the interrupt path.
// Assumes a 32-pin array and a 16-bit register bus; IRQ_PIN picks the
// interrupt source pin.
module gpio_mux_ctrl
    import gpio_mux_pkg::*;
#(
    parameter int unsigned IRQ_PIN     = 0,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned GRP_W       = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BUS_W-1:0]   bus_addr,
    input  logic               bus_wr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic [PIN_N-1:0]   pin_in,
    input  logic [GRP_W-1:0]   hs_alt_out,
    input  logic [GRP_W-1:0]   spi_alt_out,
    input  logic               spi_ss_out,
    output logic [PIN_N-1:0]   pin_out,
    output logic [2*PIN_N-1:0] pin_func,
    output logic               irq0
);

    logic [PIN_N-1:0] gpio_data;
    ctrl_t            ctrl;
    logic             ie_gpio;
    logic             clr_pending;
    logic             pending;

    gpio_mux_regs #(
        .DW (BUS_W),
        .NP (PIN_N)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .pin_in      (pin_in),
        .pending     (pending),
        .gpio_data   (gpio_data),
        .ctrl        (ctrl),
        .ie_gpio     (ie_gpio),
        .clr_pending (clr_pending)
    );

    gpio_mux_pinmux #(
        .NP       (PIN_N),
        .GRP_W    (GRP_W),
        .HS_BASE  (12),
        .SPI_BASE (8),
        .SS_PIN   (15)
    ) u_pinmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .gpio_data (gpio_data),
        .ctrl      (ctrl),
        .hs_alt    (hs_alt_out),
        .spi_alt   (spi_alt_out),
        .spi_ss    (spi_ss_out),
        .pin_out   (pin_out),
        .pin_func  (pin_func)
    );

    gpio_mux_irq #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_pin     (pin_in[IRQ_PIN]),
        .pol_rise    (ctrl.pol_rise),
        .irq_en      (ctrl.irq_en),
        .ie_gpio     (ie_gpio),
        .clr_pending (clr_pending),
        .pending     (pending),
        .irq         (irq0)
    );

    p_unmapped_low_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out[28:25] == 4'd0) && (pin_out[18:16] == 3'd0));

endmodule

// File: tb/gpio_mux_ctrl_tb_top.sv
// Scoreboard bench: driver tasks push expected items, a monitor at each
// falling edge pops and compares them against the design outputs.
module gpio_mux_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [3:0]  hs_alt_out = '0;
    logic [3:0]  spi_alt_out = '0;
    logic        spi_ss_out = 1'b0;
    logic [31:0] pin_out;
    logic [63:0] pin_func;
    logic        irq0;

    localparam logic [15:0] LO = 16'hC01E, HI = 16'hC024, CT = 16'hC006;
    localparam logic [15:0] IE = 16'hC00E, ST = 16'hC010, PL = 16'hC020, PH = 16'hC022;

    always #10 clk = ~clk;

    gpio_mux_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .hs_alt_out(hs_alt_out), .spi_alt_out(spi_alt_out), .spi_ss_out(spi_ss_out),
        .pin_out(pin_out), .pin_func(pin_func), .irq0(irq0)
    );

    int          errors = 0;
    int          checks = 0;
    int          pushed = 0;
    int          popped = 0;
    bit          done = 1'b0;
    int          kind_q[$];
    logic [63:0] exp_q[$];
    string       req_q[$];

    // Monitor: compare every queued expectation at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (kind_q.size() > 0) begin
                int          k;
                logic [63:0] e;
                logic [63:0] a;
                string       r;
                k = kind_q.pop_front();
                e = exp_q.pop_front();
                r = req_q.pop_front();
                case (k)
                    0:       a = {48'd0, bus_rdata};
                    1:       a = {32'd0, pin_out};
                    2:       a = pin_func;
                    default: a = {63'd0, irq0};
                endcase
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", r, k, a, e);
                end
                popped++;
            end
        end
    end

    task automatic expect_obs(input int k, input logic [63:0] e, input string r);
        kind_q.push_back(k);
        exp_q.push_back(e);
        req_q.push_back(r);
        pushed++;
        wait (popped == pushed);
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, input logic [15:0] e, input string r);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        @(posedge clk);
        expect_obs(0, {48'd0, e}, r);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    // Driver: stimulus and expectations.
    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        bus_read(LO, 16'h0000, "R1 lo_data");
        bus_read(CT, 16'h0000, "R1 ctrl");
        @(posedge clk); expect_obs(1, 64'd0, "R1 pin_out");
        @(posedge clk); expect_obs(2, 64'd0, "R1 pin_func");
        @(posedge clk); expect_obs(3, 64'd0, "R1 irq0");

        // R2 low data register
        bus_write(LO, 16'hA5C3);
        bus_read(LO, 16'hA5C3, "R2 lo readback");
        @(posedge clk); expect_obs(1, 64'h0000_A5C3, "R2 pin_out");

        // R3 / R4 high data register mapping and reserved bits
        bus_write(HI, 16'hFFFF);
        bus_read(HI, 16'hE1F8, "R4 hi reserved read 0");
        @(posedge clk); expect_obs(1, 64'hE1F8_A5C3, "R3 R4 pin_out all hi");
        bus_write(HI, 16'h2108);
        bus_read(HI, 16'h2108, "R3 hi readback");
        @(posedge clk); expect_obs(1, 64'h2108_A5C3, "R3 pins 29 24 19");

        // R2 readback ignores pin levels; R11 pin read
        @(negedge clk); pin_in = 32'hFFFF_0F0F;
        bus_read(LO, 16'hA5C3, "R2 lo not pin level");
        bus_read(PL, 16'h0F0F, "R11 pin_lo");
        bus_read(PH, 16'hFFFF, "R11 pin_hi");

        // R5 high-speed serial group
        @(negedge clk); hs_alt_out = 4'b0101; spi_alt_out = 4'b0011; spi_ss_out = 1'b1;
        bus_write(CT, 16'h0080);
        @(posedge clk); expect_obs(1, 64'h2108_55C3, "R5 pin_out");
        @(posedge clk); expect_obs(2, 64'h0000_0000_5500_0000, "R5 pin_func");

        // R6 SPI group
        bus_write(CT, 16'h00A0);
        @(posedge clk); expect_obs(1, 64'h2108_53C3, "R6 pin_out");
        @(posedge clk); expect_obs(2, 64'h0000_0000_55AA_0000, "R6 pin_func");

        // R7 slave-select override over the high-speed group
        bus_write(CT, 16'h00B0);
        @(posedge clk); expect_obs(1, 64'h2108_D3C3, "R7 pin_out with hs");
        @(posedge clk); expect_obs(2, 64'h0000_0000_D5AA_0000, "R7 pin_func with hs");
        @(negedge clk); spi_ss_out = 1'b0;
        bus_write(CT, 16'h0010);
        @(posedge clk); expect_obs(1, 64'h2108_25C3, "R7 pin_out alone");
        @(posedge clk); expect_obs(2, 64'h0000_0000_C000_0000, "R7 pin_func alone");

        // R4 reserved control bits
        bus_write(CT, 16'hFFFF);
        bus_read(CT, 16'h00B3, "R4 ctrl reserved");
        bus_write(CT, 16'h0000);
        @(posedge clk); expect_obs(2, 64'd0, "R5 groups back to gpio");

        // R8 interrupt, rising polarity, latency
        @(negedge clk); pin_in = 32'd0;
        idle(4);
        bus_write(IE, 16'hFFFF);
        bus_read(IE, 16'h0001, "R4 ie reserved");
        bus_write(CT, 16'h0003);
        @(negedge clk); pin_in[0] = 1'b1;
        @(posedge clk); @(posedge clk);
        expect_obs(3, 64'd0, "R8 irq not before third edge");
        @(posedge clk);
        expect_obs(3, 64'd1, "R8 irq on third edge");
        bus_read(ST, 16'h0001, "R9 status pending");
        bus_write(ST, 16'h0001);
        @(posedge clk); expect_obs(3, 64'd0, "R9 w1c clears");
        @(negedge clk); pin_in[0] = 1'b0;
        idle(6);
        @(posedge clk); expect_obs(3, 64'd0, "R8 falling ignored when rising");

        // R8 falling polarity
        bus_write(CT, 16'h0001);
        @(negedge clk); pin_in[0] = 1'b1;
        idle(6);
        @(posedge clk); expect_obs(3, 64'd0, "R8 rising ignored when falling");
        @(negedge clk); pin_in[0] = 1'b0;
        idle(6);
        @(posedge clk); expect_obs(3, 64'd1, "R8 falling edge sets");
        bus_write(ST, 16'h0000);
        @(posedge clk); expect_obs(3, 64'd1, "R9 write 0 keeps pending");
        bus_write(ST, 16'h0001);
        @(posedge clk); expect_obs(3, 64'd0, "R9 write 1 clears");

        // R8 both enables needed to set
        bus_write(IE, 16'h0000);
        bus_write(CT, 16'h0003);
        @(negedge clk); pin_in[0] = 1'b1;
        idle(6);
        @(posedge clk); expect_obs(3, 64'd0, "R8 no irq without ie");
        bus_read(ST, 16'h0000, "R8 no set without ie");

        // R9 output gated by enables while pending
        bus_write(IE, 16'h0001);
        @(negedge clk); pin_in[0] = 1'b0;
        idle(4);
        @(negedge clk); pin_in[0] = 1'b1;
        idle(6);
        @(posedge clk); expect_obs(3, 64'd1, "R8 armed edge sets");
        bus_write(IE, 16'h0000);
        @(posedge clk); expect_obs(3, 64'd0, "R9 irq gated by ie");
        bus_read(ST, 16'h0001, "R9 pending kept while gated");
        bus_write(IE, 16'h0001);
        @(posedge clk); expect_obs(3, 64'd1, "R9 irq back on");

        // R10 clear and set on the same edge
        @(negedge clk); pin_in[0] = 1'b0;
        idle(6);
        pin_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_addr = ST; bus_wdata = 16'h0001; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        @(posedge clk); expect_obs(3, 64'd1, "R10 set wins irq");
        bus_read(ST, 16'h0001, "R10 set wins status");
        bus_write(ST, 16'h0001);
        @(posedge clk); expect_obs(3, 64'd0, "R9 final clear");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule